// File: doc/BRIEF.md
# Pipelined Memory Operation Issue Unit

This block takes a stream of decoded single-word loads and stores and turns each into a bus transfer. Every transfer has a one-cycle address phase followed by a one-cycle data phase, and the bus has no wait states. When the previous operation was a load, the address phase of the next load or store is placed inside that load's data phase. This saves one cycle per operation in a chain. The overlap is refused when the next address is built from the register the load is still fetching. In that case the input handshake holds the operation back for one cycle, and its address is formed after the loaded word has been written back.

The unit contains a 16 x 32-bit register file and an address adder. The adder supports three address forms: base only, base plus index register, and base plus zero-extended immediate. A store whose data register is the destination of the load just ahead of it takes its data straight from the bus read data, so that pair still overlaps. On each completed operation the unit raises a done pulse together with that operation's cycle cost: 1 when it overlapped, 2 otherwise. A model can therefore check sequence timings.

Top module: `memop_issue`

## Requirements
- R1: The address phase drives `bus_addr` equal to reg[base] when `in_mode`=00, reg[base]+reg[index] when `in_mode`=01, and reg[base]+zero-extended `in_imm` when `in_mode`=10. `bus_write` is 1 for a store.
- R2: An operation that does not overlap has its address phase in the cycle after acceptance and its data phase in the following cycle. `done_valid` is high in that data-phase cycle with `done_cycles`=2.
- R3: A load or store that follows a load with no address dependency is accepted without a stall. Its address phase falls in the load's data phase, and it reports `done_cycles`=1.
- R4: If the next operation's base register equals the previous load's destination, `in_ready` is low for exactly one cycle and that operation reports `done_cycles`=2. The same applies to the index register, but only in mode 01.
- R5: A store whose data register is the destination of the load immediately ahead of it overlaps. Its `bus_wdata` equals the word that load read.
- R6: An operation presented right after a store sees `in_ready` low for one cycle and does not overlap.
- R7: Three back-to-back independent loads span four cycles, from the first address phase through the last done pulse.
- R8: A loaded word is written back at the end of its data phase, and any later address calculation uses it.
- R9: While and after reset, `in_ready`=1 and `bus_avalid`=0 and `done_valid`=0 until an operation is accepted.
- R10: `in_ready` is never low on two consecutive cycles.
- R11: An overlapped pair spans three cycles from its first address phase to its second done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation taken at this edge when valid |
| in_store | input | 1 | 1 = store, 0 = load |
| in_mode | input | 2 | Address form: 00 base, 01 base+index, 10 base+immediate |
| in_rd | input | 4 | Load destination / store data register |
| in_rb | input | 4 | Base register |
| in_ri | input | 4 | Index register |
| in_imm | input | 12 | Unsigned immediate offset |
| bus_avalid | output | 1 | Address phase active |
| bus_addr | output | 32 | Transfer address |
| bus_write | output | 1 | Address phase is a write |
| bus_wdata | output | 32 | Store data during data phase |
| bus_rdata | input | 32 | Load data during data phase |
| done_valid | output | 1 | An operation completes this cycle |
| done_cycles | output | 2 | Cost of the completing operation |

## Verification
In one cycle, the data phase of a load can coincide with the address phase of the next operation. Inside that cycle the read data is both written back and, for a dependent store, forwarded as that store's data. The sweep covers every pairing of load/store type, address form and dependency kind (none, base, index, store data), offered back to back. It also runs longer load chains and triples with dependencies at distance one and two. From a register and memory model kept in program order, the bench predicts the stall count, each address, each store word, each done cost and the cycle at which each done pulse should arrive.

// File: rtl/memop_pkg.sv
package memop_pkg;

  // Address form selector carried with each operation.
  typedef enum logic [1:0] {
    AM_BASE  = 2'b00,
    AM_INDEX = 2'b01,
    AM_IMM   = 2'b10
  } amode_e;

  // Cost reported for a non-overlapped and an overlapped operation.
  localparam int unsigned COST_SOLO = 2;
  localparam int unsigned COST_OVL  = 1;

endpackage

// File: rtl/memop_regfile.sv
module memop_regfile #(
  parameter  int XLEN = 32,
  parameter  int NREG = 16,
  parameter  int NRD  = 3,
  localparam int RW   = $clog2(NREG)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NRD-1:0][RW-1:0]    rd_idx,
  output logic [NRD-1:0][XLEN-1:0]  rd_data,
  input  logic                      wr_en,
  input  logic [RW-1:0]             wr_idx,
  input  logic [XLEN-1:0]           wr_data
);

  logic [XLEN-1:0] entry_q [NREG];
  logic [NREG-1:0] entry_we;

  // Per-entry write enable decode.
  always_comb begin
    entry_we = '0;
    for (int e = 0; e < NREG; e++) begin
      entry_we[e] = wr_en && (wr_idx == RW'(e));
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        entry_q[g] <= '0;
      end else if (entry_we[g]) begin
        entry_q[g] <= wr_data;
      end
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rport
    assign rd_data[p] = entry_q[rd_idx[p]];
  end

endmodule

// File: rtl/memop_agen.sv
module memop_agen
  import memop_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int IMM_W = 12
) (
  input  logic [1:0]       mode,
  input  logic [XLEN-1:0]  base_val,
  input  logic [XLEN-1:0]  index_val,
  input  logic [IMM_W-1:0] imm,
  output logic [XLEN-1:0]  addr
);

  logic [XLEN-1:0] offset;

  always_comb begin
    case (mode)
      AM_INDEX: offset = index_val;
      AM_IMM:   offset = {{(XLEN-IMM_W){1'b0}}, imm};
      default:  offset = '0;
    endcase
    addr = base_val + offset;
  end

endmodule

// File: rtl/memop_hazard.sv
module memop_hazard
  import memop_pkg::*;
#(
  parameter int RW = 4
) (
  input  logic          a_valid,
  input  logic          a_store,
  input  logic [RW-1:0] a_rd,
  input  logic [1:0]    in_mode,
  input  logic [RW-1:0] in_rb,
  input  logic [RW-1:0] in_ri,
  output logic          in_ready
);

  logic base_hit;
  logic index_hit;
  logic addr_dep;

  always_comb begin
    base_hit  = (in_rb == a_rd);
    index_hit = (in_mode == AM_INDEX) && (in_ri == a_rd);
    addr_dep  = a_valid && !a_store && (base_hit || index_hit);
    // An empty address stage always takes a new operation; an occupied one
    // hands over only when it holds a load the newcomer does not depend on.
    in_ready  = !a_valid || (!a_store && !addr_dep);
  end

endmodule

// File: rtl/memop_issue.sv
module memop_issue
  import memop_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int NREG  = 16,
  parameter int IMM_W = 12,
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_store,
  input  logic [1:0]       in_mode,
  input  logic [$clog2(NREG)-1:0] in_rd,
  input  logic [$clog2(NREG)-1:0] in_rb,
  input  logic [$clog2(NREG)-1:0] in_ri,
  input  logic [IMM_W-1:0] in_imm,
  output logic             bus_avalid,
  output logic [XLEN-1:0]  bus_addr,
  output logic             bus_write,
  output logic [XLEN-1:0]  bus_wdata,
  input  logic [XLEN-1:0]  bus_rdata,
  output logic             done_valid,
  output logic [CNT_W-1:0] done_cycles
);

  localparam int RW  = $clog2(NREG);
  localparam int NRD = 3;

  // Address-phase stage
  logic             a_valid_q, a_valid_d;
  logic             a_store_q;
  logic [1:0]       a_mode_q;
  logic [RW-1:0]    a_rd_q, a_rb_q, a_ri_q;
  logic [IMM_W-1:0] a_imm_q;
  logic             a_ovl_q, a_ovl_d;
  logic             a_en;

  // Data-phase stage
  logic             d_valid_q, d_valid_d;
  logic             d_store_q;
  logic [RW-1:0]    d_rd_q;
  logic [XLEN-1:0]  d_wdata_q, d_wdata_d;
  logic             d_ovl_q;
  logic             d_en;

  logic                      accept;
  logic [NRD-1:0][RW-1:0]    rf_ridx;
  logic [NRD-1:0][XLEN-1:0]  rf_rdata;
  logic                      rf_we;
  logic                      fwd_hit;
  logic [XLEN-1:0]           agen_addr;

  memop_hazard #(.RW(RW)) u_hazard (
    .a_valid  (a_valid_q),
    .a_store  (a_store_q),
    .a_rd     (a_rd_q),
    .in_mode  (in_mode),
    .in_rb    (in_rb),
    .in_ri    (in_ri),
    .in_ready (in_ready)
  );

  memop_regfile #(.XLEN(XLEN), .NREG(NREG), .NRD(NRD)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_idx  (rf_ridx),
    .rd_data (rf_rdata),
    .wr_en   (rf_we),
    .wr_idx  (d_rd_q),
    .wr_data (bus_rdata)
  );

  memop_agen #(.XLEN(XLEN), .IMM_W(IMM_W)) u_agen (
    .mode      (a_mode_q),
    .base_val  (rf_rdata[0]),
    .index_val (rf_rdata[1]),
    .imm       (a_imm_q),
    .addr      (agen_addr)
  );

  // Next-state logic
  always_comb begin
    accept     = in_valid && in_ready;
    a_en       = accept;
    a_valid_d  = accept;
    // Taking an op while the stage is occupied means it rides the load's data phase.
    a_ovl_d    = a_valid_q;

    rf_ridx[0] = a_rb_q;
    rf_ridx[1] = a_ri_q;
    rf_ridx[2] = a_rd_q;

    rf_we      = d_valid_q && !d_store_q;
    fwd_hit    = rf_we && (d_rd_q == a_rd_q);
    d_wdata_d  = fwd_hit ? bus_rdata : rf_rdata[2];
    d_en       = a_valid_q;
    d_valid_d  = a_valid_q;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_valid_q <= 1'b0;
      d_valid_q <= 1'b0;
    end else begin
      a_valid_q <= a_valid_d;
      d_valid_q <= d_valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_store_q <= 1'b0;
      a_mode_q  <= AM_BASE;
      a_rd_q    <= '0;
      a_rb_q    <= '0;
      a_ri_q    <= '0;
      a_imm_q   <= '0;
      a_ovl_q   <= 1'b0;
    end else if (a_en) begin
      a_store_q <= in_store;
      a_mode_q  <= in_mode;
      a_rd_q    <= in_rd;
      a_rb_q    <= in_rb;
      a_ri_q    <= in_ri;
      a_imm_q   <= in_imm;
      a_ovl_q   <= a_ovl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_store_q <= 1'b0;
      d_rd_q    <= '0;
      d_wdata_q <= '0;
      d_ovl_q   <= 1'b0;
    end else if (d_en) begin
      d_store_q <= a_store_q;
      d_rd_q    <= a_rd_q;
      d_wdata_q <= d_wdata_d;
      d_ovl_q   <= a_ovl_q;
    end
  end

  // Outputs
  always_comb begin
    bus_avalid  = a_valid_q;
    bus_addr    = agen_addr;
    bus_write   = a_store_q;
    bus_wdata   = (d_valid_q && d_store_q) ? d_wdata_q : '0;
    done_valid  = d_valid_q;
    done_cycles = d_ovl_q ? CNT_W'(COST_OVL) : CNT_W'(COST_SOLO);
  end

endmodule

// File: rtl/memop_issue_chk.sv
module memop_issue_chk #(
  parameter int RW    = 4,
  parameter int CNT_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [1:0]       in_mode,
  input logic [RW-1:0]    in_rb,
  input logic [RW-1:0]    in_ri,
  input logic             bus_avalid,
  input logic             bus_write,
  input logic             done_valid,
  input logic [CNT_W-1:0] done_cycles,
  input logic             a_valid,
  input logic             a_store,
  input logic [RW-1:0]    a_rd
);

  // R10: a stall never lasts two cycles
  a_r10_ready_low_once: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> in_ready);

  // R6: nothing overlaps the data phase of a store
  a_r6_no_overlap_after_store: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_avalid && bus_write) |=> !bus_avalid);

  // R2: every address phase is followed by exactly one completion
  a_r2_done_follows_addr: assert property (@(posedge clk) disable iff (!rst_n)
    bus_avalid |=> done_valid);

  a_r2_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_avalid |=> !done_valid);

  // R3: a cost of one only when a load's address phase came two cycles earlier
  a_r3_overlap_needs_load: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && done_cycles == CNT_W'(1)) |-> $past(bus_avalid && !bus_write, 2));

  // R4: no op is taken alongside a load it depends on
  a_r4_no_dep_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && a_valid) |->
      (!a_store && in_rb != a_rd && !(in_mode == 2'b01 && in_ri == a_rd)));

  // R3: reported cost is one or two
  a_r3_cost_range: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> (done_cycles == CNT_W'(1) || done_cycles == CNT_W'(2)));

endmodule

bind memop_issue memop_issue_chk #(.RW(RW), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_mode     (in_mode),
  .in_rb       (in_rb),
  .in_ri       (in_ri),
  .bus_avalid  (bus_avalid),
  .bus_write   (bus_write),
  .done_valid  (done_valid),
  .done_cycles (done_cycles),
  .a_valid     (a_valid_q),
  .a_store     (a_store_q),
  .a_rd        (a_rd_q)
);

// File: tb/memop_issue_tb.sv
module memop_issue_tb;

  localparam int CLK_PERIOD = 10;
  localparam int Q = CLK_PERIOD / 4;
  localparam int NOPS = 1024;

  logic        clk, rst_n;
  logic        in_valid, in_ready, in_store;
  logic [1:0]  in_mode;
  logic [3:0]  in_rd, in_rb, in_ri;
  logic [11:0] in_imm;
  logic        bus_avalid, bus_write, done_valid;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;
  logic [1:0]  done_cycles;

  memop_issue u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_store(in_store), .in_mode(in_mode), .in_rd(in_rd), .in_rb(in_rb),
    .in_ri(in_ri), .in_imm(in_imm), .bus_avalid(bus_avalid), .bus_addr(bus_addr),
    .bus_write(bus_write), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .done_valid(done_valid), .done_cycles(done_cycles)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Model state
  logic [31:0] mreg [16];
  logic [31:0] e_addr [NOPS];
  logic [31:0] e_wdata [NOPS];
  bit          e_write [NOPS];
  bit          e_first [NOPS];
  bit          e_fwd [NOPS];
  int          e_cost [NOPS];
  int          e_cum [NOPS];
  int          e_len [NOPS];
  int n_iss = 0;
  int ai = 0;
  int di = 0;
  int cum = 0;
  int seq_start = 0;
  bit pv_load = 0;
  int pv_rd = 0;

  function automatic logic [31:0] memfn(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // Monitor: address phases, completions, read data supply
  always @(negedge clk) begin
    if (rst_n) begin
      if (bus_avalid) begin
        if (e_first[ai]) seq_start = cyc;
        chk(bus_addr == e_addr[ai], "R1 address R8", bus_addr, e_addr[ai]);
        chk(bus_write == e_write[ai], "R1 direction", 32'(bus_write), 32'(e_write[ai]));
        ai++;
      end
      if (done_valid) begin
        chk(32'(done_cycles) == 32'(e_cost[di]), (e_cost[di] == 1) ? "R3 cost" : "R2 cost",
            32'(done_cycles), 32'(e_cost[di]));
        chk(cyc - seq_start + 1 == e_cum[di],
            (e_len[di] == 3) ? "R7 span" : (e_len[di] == 2) ? "R11 span" : "R3 span",
            32'(cyc - seq_start + 1), 32'(e_cum[di]));
        if (e_write[di])
          chk(bus_wdata == e_wdata[di], e_fwd[di] ? "R5 store data" : "R2 store data",
              bus_wdata, e_wdata[di]);
        bus_rdata = e_write[di] ? 32'hDEAD_BEEF : memfn(e_addr[di]);
        di++;
      end else begin
        bus_rdata = 32'hDEAD_BEEF;
      end
    end
  end

  // Present one operation at a negedge and wait for it to be taken.
  task automatic issue(input bit st, input logic [1:0] md, input int rd, input int rb,
                       input int ri, input int imm, input bit first, input int len);
    logic [31:0] addr;
    bit dep;
    int ew, cost, waits;
    addr = mreg[rb];
    if (md == 2'b01) addr = addr + mreg[ri];
    else if (md == 2'b10) addr = addr + 32'(imm);
    dep  = !first && pv_load && (rb == pv_rd || (md == 2'b01 && ri == pv_rd));
    ew   = first ? 0 : ((!pv_load || dep) ? 1 : 0);
    cost = (!first && pv_load && !dep) ? 1 : 2;
    cum  = first ? 2 : cum + cost;
    e_addr[n_iss]  = addr;
    e_write[n_iss] = st;
    e_wdata[n_iss] = mreg[rd];
    e_first[n_iss] = first;
    e_fwd[n_iss]   = st && !first && pv_load && (rd == pv_rd);
    e_cost[n_iss]  = cost;
    e_cum[n_iss]   = cum;
    e_len[n_iss]   = len;
    if (!st) mreg[rd] = memfn(addr);
    n_iss++;

    in_valid = 1'b1;
    in_store = st;
    in_mode  = md;
    in_rd    = 4'(rd);
    in_rb    = 4'(rb);
    in_ri    = 4'(ri);
    in_imm   = 12'(imm);
    waits = 0;
    #(Q);
    while (!in_ready && waits < 8) begin
      waits++;
      @(negedge clk);
      #(Q);
    end
    chk(waits == ew, dep ? "R4 stall" : (!first && !pv_load) ? "R6 stall" : "R10 stall",
        32'(waits), 32'(ew));
    @(negedge clk);
    in_valid = 1'b0;
    pv_load = !st;
    pv_rd = rd;
  endtask

  task automatic idle_gap();
    in_valid = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", di, n_iss);
    finish_run();
  end

  initial begin
    for (int r = 0; r < 16; r++) mreg[r] = '0;
    rst_n = 1'b0;
    in_valid = 1'b0; in_store = 1'b0; in_mode = 2'b00;
    in_rd = '0; in_rb = '0; in_ri = '0; in_imm = '0;
    bus_rdata = 32'hDEAD_BEEF;
    repeat (3) @(negedge clk);
    chk(in_ready && !bus_avalid && !done_valid, "R9 in reset",
        {29'd0, in_ready, bus_avalid, done_valid}, 32'h4);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(in_ready && !bus_avalid && !done_valid, "R9 after reset",
        {29'd0, in_ready, bus_avalid, done_valid}, 32'h4);

    // R3 R8: long chain of independent loads filling every register
    for (int r = 1; r < 16; r++) issue(1'b0, 2'b10, r, 0, 0, r * 8, r == 1, 16);
    issue(1'b0, 2'b10, 0, 0, 0, 12'h40, 1'b0, 16);
    idle_gap();

    // Pair sweep: type x form x type x form x dependency kind
    for (int t1 = 0; t1 < 2; t1++)
      for (int m1 = 0; m1 < 3; m1++)
        for (int t2 = 0; t2 < 2; t2++)
          for (int m2 = 0; m2 < 3; m2++)
            for (int dk = 0; dk < 4; dk++) begin
              int rb2, ri2, rd2, im;
              rb2 = 5; ri2 = 6; rd2 = 7;
              if (dk == 1) rb2 = 3;
              if (dk == 2) ri2 = 3;
              if (dk == 3) rd2 = 3;
              im = ((t1 * 18 + m1 * 6 + t2 * 3 + m2) * 36 + dk * 4) & 12'hFFC;
              issue(t1[0], 2'(m1), 3, 1, 2, im, 1'b1, 2);
              issue(t2[0], 2'(m2), rd2, rb2, ri2, im + 16, 1'b0, 2);
              idle_gap();
            end

    // R7: triples, independent and with near / far dependencies
    for (int v = 0; v < 4; v++) begin
      issue(1'b0, 2'b10, 8, 1, 0, 12'h100 + v * 16, 1'b1, 3);
      issue(1'b0, 2'b10, 9, (v == 2) ? 8 : 2, 0, 12'h104, 1'b0, 3);
      issue(v == 3, (v == 1) ? 2'b00 : 2'b01, (v == 3) ? 9 : 10, (v == 1) ? 8 : 4, 5,
            0, 1'b0, 3);
      idle_gap();
    end

    while (di < n_iss) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(di == n_iss && ai == n_iss, "R2 completions", 32'(di), 32'(n_iss));
    finish_run();
  end

endmodule